// File: doc/BRIEF.md
# Two-Pass 32-bit Integer ALU on a 16-bit Slice

This block performs 32-bit signed integer arithmetic, logic and shift operations with a single 16-bit ALU slice that is used twice. The operands are presented as 32-bit values, each made of a low and a high 16-bit word. The low words are processed in the first pass. The carry out of that pass is kept in a register and fed into the second pass, which processes the high words. Operations that select the 16-bit width take only the first pass. A single-digit excess-3 decimal add is also provided and always takes one pass.

A client raises `start` for one cycle with the operation, width, operands and shift count. The block then reports `busy` until it raises `done` for one cycle. From that cycle on, `result` and the four flags (carry, zero, negative, overflow) hold until the next accepted operation finishes a pass. The number of cycles is fixed for each width, so the block fits within a fixed memory-cycle budget.

The sequencer has three states. It moves from IDLE to LOW when `start` is seen. It moves from LOW to HIGH when the accepted operation is 32 bits wide, or from LOW to IDLE for a single-pass operation. It always moves from HIGH to IDLE. `done` is registered on the LOW-to-IDLE and HIGH-to-IDLE transitions.

Top module: `split_alu32`

## Requirements
- R1: After reset, `busy`, `done`, `result` and all four flags are 0.
- R2: `start` is accepted only in IDLE. A `start` raised while `busy` is 1 is ignored: the running operation keeps its operands and result, and no extra `done` occurs.
- R3: `done` is high for exactly one cycle. It follows the third rising edge, counted from the edge that samples `start`, for a 32-bit operation, and the second such edge for a 16-bit or excess-3 operation. `busy` is high from the edge after acceptance until `done` rises, and is low while `done` is high.
- R4: op=0 adds: `result` = a+b mod 2^32, with the carry passed from the low to the high half. C is the carry out of bit 31. V is signed overflow.
- R5: op=1 subtracts: `result` = a-b mod 2^32. C=1 when there is no borrow (a >= b unsigned). V is signed overflow.
- R6: op=2 gives AND, op=3 gives OR and op=4 gives XOR, bitwise. C and V are 0.
- R7: op=5 shifts a left by `shamt` (0..15), filling with zeros. Bits leave the low half and enter the high half. C and V are 0.
- R8: op=6 shifts a right arithmetically by `shamt` (0..15), filling with the sign. Bits leave the high half and enter the low half. C and V are 0.
- R9: With `wide`=0, ops 0..6 act on a[15:0] and b[15:0] only. `result[31:16]` is 0. C, V and N come from the 16-bit result, with N taken from bit 15.
- R10: op=7 adds the excess-3 digits a[3:0] and b[3:0] in one pass, whatever `wide` is. A 5-bit raw sum is formed. If its bit 4 is set, the digit is raw[3:0]+3 and C=1; otherwise the digit is raw[3:0]-3 (mod 16) and C=0. `result` = the digit zero-extended, Z = (digit==0), N=V=0.
- R11: Z is 1 exactly when the whole result is 0, built as the AND of the per-pass zero indications. For a 32-bit operation, N is result bit 31.
- R12: While `busy` is 0, `result` and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation (sampled in IDLE only) |
| op | input | 3 | Operation code, see R4 to R10 |
| wide | input | 1 | 1 = 32-bit operation, 0 = 16-bit |
| a | input | 32 | First operand (high word : low word) |
| b | input | 32 | Second operand |
| shamt | input | 4 | Immediate shift count |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result and flags are final |
| result | output | 32 | Operation result |
| flag_c | output | 1 | Carry / no-borrow |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result is negative |
| flag_v | output | 1 | Signed overflow |

## Verification
The assertions assume that the client sees `done` only as the end of an operation it started in IDLE, and that a `start` raised during `busy` leaves no trace. They also assume that `op`, `wide` and the operands matter only in the cycle where `start` meets IDLE. The stimulus drives inputs shortly after a rising edge. It starts each operation only once the previous one has finished, apart from one deliberate `start` raised while `busy` with different operands. It keeps `shamt` within 0..15, as the 4-bit port enforces. Excess-3 inputs are also given as arbitrary nibbles, because R10 defines the result from the raw sum alone.

// File: rtl/split_alu_pkg.sv
package split_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SAR = 3'd6,
        OP_XS3 = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HIGH = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/split_alu_slice.sv
// One half-width ALU slice; used once per pass.
module split_alu_slice
    import split_alu_pkg::*;
#(
    parameter int HW = 16,
    localparam int SHW = $clog2(HW)
) (
    input  alu_op_e          op,
    input  logic [HW-1:0]    x,
    input  logic [HW-1:0]    y,
    input  logic [HW-1:0]    fill,   // bits shifted in from the neighbouring half
    input  logic [SHW-1:0]   sh,
    input  logic             cin,
    output logic [HW-1:0]    r,
    output logic             cout,
    output logic             ovf,
    output logic             zero
);

    logic [HW-1:0]   y_eff;
    logic [HW:0]     sum;
    logic [2*HW-1:0] lsh;
    logic [2*HW-1:0] rsh;

    always_comb begin
        y_eff = (op == OP_SUB) ? ~y : y;
        sum   = {1'b0, x} + {1'b0, y_eff} + {{HW{1'b0}}, cin};
        lsh   = {x, fill} << sh;
        rsh   = {fill, x} >> sh;
        r     = '0;
        cout  = 1'b0;
        ovf   = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                r    = sum[HW-1:0];
                cout = sum[HW];
                ovf  = (x[HW-1] == y_eff[HW-1]) && (sum[HW-1] != x[HW-1]);
            end
            OP_AND:  r = x & y;
            OP_OR:   r = x | y;
            OP_XOR:  r = x ^ y;
            OP_SHL:  r = lsh[2*HW-1:HW];
            OP_SAR:  r = rsh[HW-1:0];
            default: r = '0;
        endcase
        zero = (r == '0);
    end

endmodule

// File: rtl/split_alu_xs3.sv
// Single-digit excess-3 adder with bias correction.
module split_alu_xs3 #(
    parameter int DW   = 4,
    parameter int BIAS = 3
) (
    input  logic [DW-1:0] da,
    input  logic [DW-1:0] db,
    output logic [DW-1:0] dsum,
    output logic          dcarry
);

    localparam logic [DW-1:0] BIAS_V = DW'(BIAS);

    logic [DW:0] raw;

    always_comb begin
        raw    = {1'b0, da} + {1'b0, db};
        dcarry = raw[DW];
        dsum   = dcarry ? (raw[DW-1:0] + BIAS_V) : (raw[DW-1:0] - BIAS_V);
    end

endmodule

// File: rtl/split_alu_seq.sv
// Pass sequencer: IDLE -> LOW -> (HIGH) -> IDLE.
module split_alu_seq
    import split_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wide_req,
    output seq_state_e state,
    output logic       accept,
    output logic       wide_q,
    output logic       done
);

    seq_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        accept = (state == SEQ_IDLE) && start;
        nxt    = state;
        unique case (state)
            SEQ_IDLE: if (start) nxt = SEQ_LOW;
            SEQ_LOW:  nxt = wide_q ? SEQ_HIGH : SEQ_IDLE;
            SEQ_HIGH: nxt = SEQ_IDLE;
            default:  nxt = SEQ_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            done <= ((state == SEQ_LOW) && !wide_q) || (state == SEQ_HIGH);
            if (accept) wide_q <= wide_req;
        end
    end

endmodule

// File: rtl/split_alu32.sv
module split_alu32
    import split_alu_pkg::*;
#(
    parameter int HW = 16,
    parameter int DW = 4,
    localparam int WW  = 2 * HW,
    localparam int SHW = $clog2(HW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op,
    input  logic           wide,
    input  logic [WW-1:0]  a,
    input  logic [WW-1:0]  b,
    input  logic [SHW-1:0] shamt,
    output logic           busy,
    output logic           done,
    output logic [WW-1:0]  result,
    output logic           flag_c,
    output logic           flag_z,
    output logic           flag_n,
    output logic           flag_v
);

    seq_state_e     state;
    logic           accept;
    logic           wide_q;

    alu_op_e        op_q;
    logic [WW-1:0]  a_q, b_q;
    logic [SHW-1:0] sh_q;
    logic [HW-1:0]  lo_q, hi_q;
    logic           carry_q, zlo_q;
    alu_flags_t     flags_q;

    logic           in_hi;
    logic [HW-1:0]  s_x, s_y, s_fill, s_r;
    logic           s_cin, s_cout, s_ovf, s_zero;
    logic [DW-1:0]  d_sum;
    logic           d_carry;
    logic           wide_req;

    assign wide_req = wide && (alu_op_e'(op) != OP_XS3);

    split_alu_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wide_req (wide_req),
        .state    (state),
        .accept   (accept),
        .wide_q   (wide_q),
        .done     (done)
    );

    // operand steering for the current pass
    always_comb begin
        in_hi = (state == SEQ_HIGH);
        s_x   = in_hi ? a_q[WW-1:HW] : a_q[HW-1:0];
        s_y   = in_hi ? b_q[WW-1:HW] : b_q[HW-1:0];
        s_cin = in_hi ? carry_q : (op_q == OP_SUB);
        unique case (op_q)
            OP_SHL:  s_fill = in_hi ? a_q[HW-1:0] : '0;
            OP_SAR:  begin
                if (in_hi)       s_fill = {HW{a_q[WW-1]}};
                else if (wide_q) s_fill = a_q[WW-1:HW];
                else             s_fill = {HW{a_q[HW-1]}};
            end
            default: s_fill = '0;
        endcase
    end

    split_alu_slice #(.HW(HW)) u_slice (
        .op   (op_q),
        .x    (s_x),
        .y    (s_y),
        .fill (s_fill),
        .sh   (sh_q),
        .cin  (s_cin),
        .r    (s_r),
        .cout (s_cout),
        .ovf  (s_ovf),
        .zero (s_zero)
    );

    split_alu_xs3 #(.DW(DW)) u_xs3 (
        .da     (a_q[DW-1:0]),
        .db     (b_q[DW-1:0]),
        .dsum   (d_sum),
        .dcarry (d_carry)
    );

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_ADD;
            a_q     <= '0;
            b_q     <= '0;
            sh_q    <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            carry_q <= 1'b0;
            zlo_q   <= 1'b0;
            flags_q <= '0;
        end else begin
            if (accept) begin
                op_q <= alu_op_e'(op);
                a_q  <= a;
                b_q  <= b;
                sh_q <= shamt;
            end
            if (state == SEQ_LOW) begin
                if (op_q == OP_XS3) begin
                    lo_q    <= {{(HW-DW){1'b0}}, d_sum};
                    hi_q    <= '0;
                    flags_q <= '{c: d_carry, z: (d_sum == '0), n: 1'b0, v: 1'b0};
                end else begin
                    lo_q    <= s_r;
                    carry_q <= s_cout;
                    zlo_q   <= s_zero;
                    if (!wide_q) begin
                        hi_q    <= '0;
                        flags_q <= '{c: s_cout, z: s_zero, n: s_r[HW-1], v: s_ovf};
                    end
                end
            end
            if (state == SEQ_HIGH) begin
                hi_q    <= s_r;
                flags_q <= '{c: s_cout, z: zlo_q && s_zero, n: s_r[HW-1], v: s_ovf};
            end
        end
    end

    always_comb begin
        busy   = (state != SEQ_IDLE);
        result = {hi_q, lo_q};
        flag_c = flags_q.c;
        flag_z = flags_q.z;
        flag_n = flags_q.n;
        flag_v = flags_q.v;
    end

endmodule

// File: rtl/split_alu_chk.sv
module split_alu_chk #(
    parameter int HW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [2:0]      op,
    input logic            wide,
    input logic            busy,
    input logic            done,
    input logic [2*HW-1:0] result,
    input logic            flag_c,
    input logic            flag_z,
    input logic            flag_n,
    input logic            flag_v
);

    logic [1:0] pass_cnt;
    logic       narrow_cap;
    logic [2:0] op_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_cnt   <= '0;
            narrow_cap <= 1'b0;
            op_cap     <= '0;
        end else if (start && !busy) begin
            pass_cnt   <= '0;
            narrow_cap <= !wide || (op == 3'd7);
            op_cap     <= op;
        end else if (busy) begin
            pass_cnt <= pass_cnt + 2'd1;
        end
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r3_pass_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass_cnt == (narrow_cap ? 2'd1 : 2'd2)));

    a_r9_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && narrow_cap) |-> (result[2*HW-1:HW] == '0));

    a_r6_logic_no_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_cap >= 3'd2) && (op_cap <= 3'd4)) |-> (!flag_c && !flag_v));

    a_r10_xs3_digit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_cap == 3'd7)) |-> ((result[2*HW-1:4] == '0) && !flag_n && !flag_v));

    a_r11_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (result == '0)));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)
                   && $stable(flag_n) && $stable(flag_v)));

endmodule

bind split_alu32 split_alu_chk #(.HW(HW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .wide   (wide),
    .busy   (busy),
    .done   (done),
    .result (result),
    .flag_c (flag_c),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_v (flag_v)
);

// File: tb/split_alu32_test.sv
`timescale 1ns/1ps
module split_alu32_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        wide = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [3:0]  shamt = '0;
    logic        busy, done;
    logic [31:0] result;
    logic        flag_c, flag_z, flag_n, flag_v;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int due = -1;
    int begin_c = -1;
    bit running = 1'b0;
    logic [35:0] exp_q[$];
    logic [2:0]  cur_op;
    logic        cur_w;
    string       done_tag = "R3";
    logic [31:0] last_res = '0;
    logic [3:0]  last_flags = '0;

    split_alu32 uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .a(a), .b(b), .shamt(shamt), .busy(busy), .done(done),
        .result(result), .flag_c(flag_c), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic string tag_of(input logic [2:0] o, input logic w);
        if (o == 3'd7) return "R10";
        if (!w) return "R9";
        case (o)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R6";
        endcase
    endfunction

    // behavioural reference: whole-word arithmetic, {result, c, z, n, v}
    function automatic logic [35:0] ref_calc(input logic [2:0] o, input logic w,
                                             input logic [31:0] x, input logic [31:0] y,
                                             input int sh);
        longint m, ux, uy, t, r;
        int top;
        logic c, v, sx, sy;
        int raw, d;
        if (o == 3'd7) begin
            raw = int'(x[3:0]) + int'(y[3:0]);
            if (raw > 15) begin d = (raw + 3) % 16; c = 1'b1; end
            else          begin d = (raw + 13) % 16; c = 1'b0; end
            return {32'(d), c, (d == 0), 1'b0, 1'b0};
        end
        top = w ? 31 : 15;
        m   = w ? 64'hFFFF_FFFF : 64'hFFFF;
        ux  = longint'(x) & m;
        uy  = longint'(y) & m;
        c = 1'b0; v = 1'b0; r = 0;
        case (o)
            3'd0, 3'd1: begin
                if (o == 3'd1) t = ux + ((~uy) & m) + 1;
                else           t = ux + uy;
                r  = t & m;
                c  = t[top+1];
                sx = ux[top];
                sy = (o == 3'd1) ? ~uy[top] : uy[top];
                v  = (sx == sy) && (r[top] != sx);
            end
            3'd2: r = ux & uy;
            3'd3: r = ux | uy;
            3'd4: r = ux ^ uy;
            3'd5: r = (ux << sh) & m;
            default: begin
                t = ux[top] ? (ux | ~m) : ux;
                r = (t >>> sh) & m;
            end
        endcase
        return {r[31:0], c, (r == 0), r[top], v};
    endfunction

    task automatic run_op(input logic [2:0] o, input logic w, input logic [31:0] x,
                          input logic [31:0] y, input int sh, input bit intrude);
        @(posedge clk); #1;
        op = o; wide = w; a = x; b = y; shamt = 4'(sh); start = 1'b1;
        cur_op = o; cur_w = w;
        exp_q.push_back(ref_calc(o, w, x, y, sh));
        begin_c = cyc;
        due = cyc + (((o == 3'd7) || !w) ? 2 : 3);
        done_tag = intrude ? "R2" : "R3";
        @(posedge clk); #1;
        if (intrude) begin
            // R2: start while busy with other operands must be ignored
            a = ~x; b = x ^ 32'h5A5A_A5A5; op = 3'd4;
            @(posedge clk); #1;
        end
        start = 1'b0;
        while (cyc <= due + 1) @(posedge clk);
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && running) begin
            bit eb, ed;
            logic [35:0] e;
            eb = (due >= 0) && (cyc > begin_c) && (cyc < due);
            ed = (due >= 0) && (cyc == due);
            chk(busy == eb, done_tag, "busy", 32'(busy), 32'(eb));
            chk(done == ed, done_tag, "done", 32'(done), 32'(ed));
            if (ed && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(result == e[35:4], tag_of(cur_op, cur_w), "result", result, e[35:4]);
                chk(flag_c == e[3], tag_of(cur_op, cur_w), "flag_c", 32'(flag_c), 32'(e[3]));
                chk(flag_v == e[0], tag_of(cur_op, cur_w), "flag_v", 32'(flag_v), 32'(e[0]));
                chk(flag_z == e[2], "R11", "flag_z", 32'(flag_z), 32'(e[2]));
                chk(flag_n == e[1], "R11", "flag_n", 32'(flag_n), 32'(e[1]));
                last_res   = result;
                last_flags = {flag_c, flag_z, flag_n, flag_v};
            end else if (!eb) begin
                chk(result == last_res, "R12", "idle result", result, last_res);
                chk({flag_c, flag_z, flag_n, flag_v} == last_flags, "R12", "idle flags",
                    32'({flag_c, flag_z, flag_n, flag_v}), 32'(last_flags));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy", 32'(busy), 32'd0);
        chk(done == 1'b0, "R1", "done", 32'(done), 32'd0);
        chk(result == '0, "R1", "result", result, 32'd0);
        chk({flag_c, flag_z, flag_n, flag_v} == 4'd0, "R1", "flags",
            32'({flag_c, flag_z, flag_n, flag_v}), 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(result == '0, "R1", "result after release", result, 32'd0);
        running = 1'b1;

        // R4: add, carry across halves, overflow, wrap to zero
        run_op(3'd0, 1'b1, 32'h0000_FFFF, 32'h0000_0001, 0, 1'b0);
        run_op(3'd0, 1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 0, 1'b0);
        run_op(3'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 0, 1'b0);
        // R5: subtract with borrow and overflow
        run_op(3'd1, 1'b1, 32'd5, 32'd7, 0, 1'b0);
        run_op(3'd1, 1'b1, 32'h8000_0000, 32'd1, 0, 1'b0);
        run_op(3'd1, 1'b1, 32'h0001_0000, 32'h0000_0001, 0, 1'b0);
        // R6: logic
        run_op(3'd2, 1'b1, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 1'b0);
        run_op(3'd3, 1'b1, 32'h8000_0000, 32'h0000_0001, 0, 1'b0);
        run_op(3'd4, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 1'b0);
        // R7 / R8: shifts crossing the halves
        run_op(3'd5, 1'b1, 32'h0001_8001, 32'd0, 15, 1'b0);
        run_op(3'd5, 1'b1, 32'h1234_5678, 32'd0, 0, 1'b0);
        run_op(3'd6, 1'b1, 32'h8000_0001, 32'd0, 4, 1'b0);
        run_op(3'd6, 1'b1, 32'h0001_0000, 32'd0, 1, 1'b0);
        // R9: 16-bit single pass
        run_op(3'd0, 1'b0, 32'h1234_FFFF, 32'h0000_0001, 0, 1'b0);
        run_op(3'd1, 1'b0, 32'hFFFF_0003, 32'h0000_0005, 0, 1'b0);
        run_op(3'd6, 1'b0, 32'h0000_8000, 32'd0, 3, 1'b0);
        run_op(3'd0, 1'b0, 32'h0000_7FFF, 32'h0000_0001, 0, 1'b0);
        // R10: excess-3 digit add, both wide values
        run_op(3'd7, 1'b0, 32'h0000_0008, 32'h0000_0007, 0, 1'b0);
        run_op(3'd7, 1'b1, 32'hFFFF_000A, 32'hFFFF_000B, 0, 1'b0);
        run_op(3'd7, 1'b1, 32'h0000_0003, 32'h0000_0003, 0, 1'b0);
        // R2: start while busy is ignored
        run_op(3'd0, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF, 0, 1'b1);
        // mixed patterns
        for (int i = 0; i < 60; i++)
            run_op(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), $urandom, $urandom,
                   int'($urandom_range(0, 15)), 1'b0);
        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule